// File: doc/BRIEF.md
# Fuzzy Rule Evaluator and Weighted-Average Defuzzifier with Clamped Integrator

This block is the inference core of a fuzzy proportional-integral controller. It takes two signed, scaled controller inputs, along with the membership degrees already computed for each input. It evaluates every rule pairing of one input-0 term with one input-1 term at the same time. The firing strength of each rule is the smaller of its two degrees.

Each rule has a first-order consequent that is linear in both inputs. The block forms the average of all consequents, each weighted by its rule's firing strength. It divides in fixed point and outputs the result as a signed increment.

The increment is added into a running sum every clock. The controller output is that sum held between a lower and an upper limit. A parameter selects one of two datapaths. One is combinational, with the increment valid in the same cycle. The other is a four-stage registered pipeline, which allows a shorter clock period.

Top module: `ts_fuzzy_incr`

## Requirements
- R1: Membership degree j of input 0 sits in `mu0_i[j*N +: N]`, and degree j of input 1 sits in `mu1_i[j*N +: N]`. Each degree is an unsigned fraction with N fractional bits. Rule g = l*F1 + k fires with strength min(degree l of input 0, degree k of input 1).
- R2: The consequent of rule g is z_g = A_g*x0 + B_g*x1 + C_g, with all coefficients in units of 2^-N. The coefficients are A_g = ((37g) mod 97) - 48, B_g = ((53g) mod 89) - 44 and C_g = ((29g) mod 61) - 30.
- R3: Inputs `x0_i`/`x1_i` and the output `incr_o` are signed two's complement with N fractional bits. The increment is the sum over g of strength_g*z_g, divided by the sum of strengths, truncated toward zero to a multiple of 2^-N.
- R4: When every rule strength is zero, the increment is zero.
- R5: A quotient outside the signed V-bit range is saturated to -2^(V-1) or 2^(V-1)-1.
- R6: With PIPE=0, `incr_o` follows the inputs within the same cycle.
- R7: With PIPE=1, the input values present during cycle c determine `incr_o` during cycle c+4.
- R8: At each rising edge, the internal sum adds the sign-extended `incr_o`. The sum is kept unclamped at AW bits.
- R9: `ctrl_o` equals the internal sum clamped to [VMIN, VMAX].
- R10: Asynchronous active-low reset clears the sum and the pipeline registers, so `incr_o` and `ctrl_o` read zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| x0_i | input | V | First controller input, signed, N fractional bits |
| x1_i | input | V | Second controller input, signed, N fractional bits |
| mu0_i | input | F0*N | Packed membership degrees of the first input |
| mu1_i | input | F1*N | Packed membership degrees of the second input |
| incr_o | output | V | Defuzzified signed increment |
| ctrl_o | output | AW | Clamped accumulated controller output |

## Verification
The bench builds two instances of the block.

The first is combinational, with three terms per input, four fractional bits and a five-bit increment. This shrinks the input space to 32 by 32 values, so the bench sweeps every input pair with varied degree patterns. That sweep covers zero total strength, single-rule and two-rule firing, and saturation at both ends.

The second instance uses the default seven-by-seven rule grid in pipelined form, with narrow output limits. Its stimulus is chosen so that the running sum first climbs past the upper limit and then falls below the lower one. This checks the four-cycle latency, the integrator, and both clamp edges.

// File: rtl/ts_fuzzy_pkg.sv
package ts_fuzzy_pkg;

  // Consequent coefficients of rule g, integers in units of 2^-N.
  function automatic int coef_a(input int g);
    return ((g * 37) % 97) - 48;
  endfunction

  function automatic int coef_b(input int g);
    return ((g * 53) % 89) - 44;
  endfunction

  function automatic int coef_c(input int g);
    return ((g * 29) % 61) - 30;
  endfunction

endpackage

// File: rtl/ts_rule_bank.sv
module ts_rule_bank #(
  parameter int F0 = 7,
  parameter int F1 = 7,
  parameter int N  = 7
) (
  input  logic [F0*N-1:0]    mu0_i,
  input  logic [F1*N-1:0]    mu1_i,
  output logic [F0*F1*N-1:0] str_o
);

  // One comparator plus select per rule; rule index g = l*F1 + k.
  for (genvar l = 0; l < F0; l++) begin : g_row
    for (genvar k = 0; k < F1; k++) begin : g_col
      logic [N-1:0] deg_a;
      logic [N-1:0] deg_b;
      assign deg_a = mu0_i[l*N +: N];
      assign deg_b = mu1_i[k*N +: N];
      assign str_o[(l*F1+k)*N +: N] = (deg_a > deg_b) ? deg_b : deg_a;
    end
  end

endmodule

// File: rtl/ts_weight_sum.sv
module ts_weight_sum
  import ts_fuzzy_pkg::*;
#(
  parameter int F0 = 7,
  parameter int F1 = 7,
  parameter int N  = 7,
  parameter int V  = 8,
  parameter int CW = 8,
  parameter int ZW = 18,
  parameter int WW = 26,
  parameter int NW = 33,
  parameter int DW = 14
) (
  input  logic signed [V-1:0]      x0_i,
  input  logic signed [V-1:0]      x1_i,
  input  logic [F0*F1*N-1:0]       str_i,
  output logic signed [NW-1:0]     num_o,
  output logic [DW-1:0]            den_o
);

  localparam int R = F0 * F1;

  logic signed [WW-1:0] term_arr [R];
  logic [N-1:0]         str_arr  [R];

  logic signed [ZW-1:0] x0_e;
  logic signed [ZW-1:0] x1_e;
  assign x0_e = {{(ZW-V){x0_i[V-1]}}, x0_i};
  assign x1_e = {{(ZW-V){x1_i[V-1]}}, x1_i};

  for (genvar g = 0; g < R; g++) begin : g_term
    localparam logic signed [CW-1:0] CA = CW'(coef_a(g));
    localparam logic signed [CW-1:0] CB = CW'(coef_b(g));
    localparam logic signed [CW-1:0] CC = CW'(coef_c(g));
    logic signed [ZW-1:0] a_e;
    logic signed [ZW-1:0] b_e;
    logic signed [ZW-1:0] c_e;
    logic signed [ZW-1:0] cons;
    logic signed [WW-1:0] s_e;
    logic signed [WW-1:0] z_e;
    assign a_e  = {{(ZW-CW){CA[CW-1]}}, CA};
    assign b_e  = {{(ZW-CW){CB[CW-1]}}, CB};
    // C is aligned to the product scale 2^-2N.
    assign c_e  = {{(ZW-CW-N){CC[CW-1]}}, CC, {N{1'b0}}};
    assign cons = a_e * x0_e + b_e * x1_e + c_e;
    assign str_arr[g] = str_i[g*N +: N];
    assign s_e  = {{(WW-N){1'b0}}, str_i[g*N +: N]};
    assign z_e  = {{(WW-ZW){cons[ZW-1]}}, cons};
    assign term_arr[g] = s_e * z_e;
  end

  always_comb begin
    logic signed [NW-1:0] nsum;
    logic [DW-1:0]        dsum;
    nsum = '0;
    dsum = '0;
    for (int g = 0; g < R; g++) begin
      nsum = nsum + {{(NW-WW){term_arr[g][WW-1]}}, term_arr[g]};
      dsum = dsum + {{(DW-N){1'b0}}, str_arr[g]};
    end
    num_o = nsum;
    den_o = dsum;
  end

endmodule

// File: rtl/ts_divider.sv
module ts_divider #(
  parameter int N  = 7,
  parameter int V  = 8,
  parameter int NW = 33,
  parameter int DW = 14
) (
  input  logic signed [NW-1:0] num_i,
  input  logic [DW-1:0]        den_i,
  output logic signed [V-1:0]  q_o
);

  localparam int QW = NW + 1;
  localparam logic signed [QW-1:0] QMAX = QW'((64'sd1 <<< (V-1)) - 64'sd1);
  localparam logic signed [QW-1:0] QMIN = -QMAX - QW'(1);

  // num is at scale 2^-3N, den at 2^-N; shifting den by N yields a 2^-N quotient.
  function automatic logic signed [V-1:0] div_sat(input logic signed [NW-1:0] n,
                                                  input logic [DW-1:0] d);
    logic signed [QW-1:0] nn;
    logic signed [QW-1:0] dd;
    logic signed [QW-1:0] qq;
    if (d == '0) return '0;
    nn = {n[NW-1], n};
    dd = {{(QW-DW-N){1'b0}}, d, {N{1'b0}}};
    qq = nn / dd;
    if (qq > QMAX) qq = QMAX;
    else if (qq < QMIN) qq = QMIN;
    return qq[V-1:0];
  endfunction

  assign q_o = div_sat(num_i, den_i);

endmodule

// File: rtl/ts_integrator.sv
module ts_integrator #(
  parameter int     V    = 8,
  parameter int     AW   = 24,
  parameter longint VMIN = -2000,
  parameter longint VMAX = 2000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [V-1:0]  incr_i,
  output logic signed [AW-1:0] acc_o,
  output logic signed [AW-1:0] ctrl_o
);

  localparam logic signed [AW-1:0] LO = AW'(VMIN);
  localparam logic signed [AW-1:0] HI = AW'(VMAX);

  function automatic logic signed [AW-1:0] clamp(input logic signed [AW-1:0] v);
    if (v > HI) return HI;
    if (v < LO) return LO;
    return v;
  endfunction

  logic signed [AW-1:0] acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_q + {{(AW-V){incr_i[V-1]}}, incr_i};
  end

  assign acc_o  = acc_q;
  assign ctrl_o = clamp(acc_q);

endmodule

// File: rtl/ts_fuzzy_incr.sv
module ts_fuzzy_incr #(
  parameter int     F0   = 7,
  parameter int     F1   = 7,
  parameter int     N    = 7,
  parameter int     V    = 8,
  parameter int     CW   = 8,
  parameter int     AW   = 24,
  parameter longint VMIN = -2000,
  parameter longint VMAX = 2000,
  parameter bit     PIPE = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [V-1:0]  x0_i,
  input  logic signed [V-1:0]  x1_i,
  input  logic [F0*N-1:0]      mu0_i,
  input  logic [F1*N-1:0]      mu1_i,
  output logic signed [V-1:0]  incr_o,
  output logic signed [AW-1:0] ctrl_o
);

  localparam int R   = F0 * F1;
  localparam int LGR = $clog2(R) + 1;
  localparam int ZW  = V + CW + 2;
  localparam int WW  = ZW + N + 1;
  localparam int NW  = WW + LGR;
  localparam int DW  = N + LGR;

  // Stage boundaries: a = after input capture, b = after rules,
  // c = after weighted sums, q = divider output.
  logic signed [V-1:0]  x0_a, x1_a, x0_b, x1_b;
  logic [F0*N-1:0]      mu0_a;
  logic [F1*N-1:0]      mu1_a;
  logic [R*N-1:0]       str_w, str_b;
  logic signed [NW-1:0] num_w, num_c;
  logic [DW-1:0]        den_w, den_c;
  logic signed [V-1:0]  q_w;
  logic signed [AW-1:0] acc_w;

  ts_rule_bank #(.F0(F0), .F1(F1), .N(N)) u_rules (
    .mu0_i(mu0_a), .mu1_i(mu1_a), .str_o(str_w)
  );

  ts_weight_sum #(.F0(F0), .F1(F1), .N(N), .V(V), .CW(CW),
                  .ZW(ZW), .WW(WW), .NW(NW), .DW(DW)) u_wsum (
    .x0_i(x0_b), .x1_i(x1_b), .str_i(str_b), .num_o(num_w), .den_o(den_w)
  );

  ts_divider #(.N(N), .V(V), .NW(NW), .DW(DW)) u_div (
    .num_i(num_c), .den_i(den_c), .q_o(q_w)
  );

  if (PIPE) begin : g_pipe
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        x0_a <= '0; x1_a <= '0; mu0_a <= '0; mu1_a <= '0;
        x0_b <= '0; x1_b <= '0; str_b <= '0;
        num_c <= '0; den_c <= '0;
        incr_o <= '0;
      end else begin
        x0_a  <= x0_i;  x1_a  <= x1_i;
        mu0_a <= mu0_i; mu1_a <= mu1_i;
        x0_b  <= x0_a;  x1_b  <= x1_a;  str_b <= str_w;
        num_c <= num_w; den_c <= den_w;
        incr_o <= q_w;
      end
    end
  end else begin : g_comb
    assign x0_a  = x0_i;  assign x1_a  = x1_i;
    assign mu0_a = mu0_i; assign mu1_a = mu1_i;
    assign x0_b  = x0_a;  assign x1_b  = x1_a;  assign str_b = str_w;
    assign num_c = num_w; assign den_c = den_w;
    assign incr_o = q_w;
  end

  ts_integrator #(.V(V), .AW(AW), .VMIN(VMIN), .VMAX(VMAX)) u_integ (
    .clk(clk), .rst_n(rst_n), .incr_i(incr_o), .acc_o(acc_w), .ctrl_o(ctrl_o)
  );

endmodule

// File: rtl/ts_fuzzy_chk.sv
module ts_fuzzy_chk #(
  parameter int     V    = 8,
  parameter int     AW   = 24,
  parameter int     DW   = 14,
  parameter longint VMIN = -2000,
  parameter longint VMAX = 2000
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [DW-1:0]        den_c,
  input logic signed [V-1:0]  q_w,
  input logic signed [V-1:0]  incr_o,
  input logic signed [AW-1:0] acc_w,
  input logic signed [AW-1:0] ctrl_o
);

  localparam logic signed [AW-1:0] LO = AW'(VMIN);
  localparam logic signed [AW-1:0] HI = AW'(VMAX);

  // R4: zero total strength yields a zero quotient.
  p_zero_den_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (den_c == '0) |-> (q_w == '0));

  // R8: the sum advances by exactly the increment seen at the previous edge.
  p_acc_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (acc_w == $past(acc_w) + $past({{(AW-V){incr_o[V-1]}}, incr_o})));

  // R9: output never leaves the limits.
  p_ctrl_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_o >= LO) && (ctrl_o <= HI));

  // R9: above the upper limit the output sits on it.
  p_clamp_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_w > HI) |-> (ctrl_o == HI));

  // R9: below the lower limit the output sits on it.
  p_clamp_lo_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_w < LO) |-> (ctrl_o == LO));

endmodule

bind ts_fuzzy_incr ts_fuzzy_chk #(
  .V(V), .AW(AW), .DW(DW), .VMIN(VMIN), .VMAX(VMAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .den_c(den_c), .q_w(q_w),
  .incr_o(incr_o), .acc_w(acc_w), .ctrl_o(ctrl_o)
);

// File: tb/tb_ts_fuzzy_incr.sv
module tb_ts_fuzzy_incr;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 70;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int ncheck = 0;
  int nerr = 0;
  int unsigned seed = 32'h1234_5678;

  // Small one-shot configuration: 3x3 rules, N=4, V=5
  logic signed [4:0]  os_x0 = '0, os_x1 = '0;
  logic [11:0]        os_mu0 = '0, os_mu1 = '0;
  logic signed [4:0]  os_incr;
  logic signed [15:0] os_ctrl;

  ts_fuzzy_incr #(.F0(3), .F1(3), .N(4), .V(5), .CW(8), .AW(16),
                  .VMIN(-1000), .VMAX(1000), .PIPE(1'b0)) dut_os (
    .clk(clk), .rst_n(rst_n), .x0_i(os_x0), .x1_i(os_x1),
    .mu0_i(os_mu0), .mu1_i(os_mu1), .incr_o(os_incr), .ctrl_o(os_ctrl)
  );

  // Default-size pipelined configuration with narrow limits
  logic signed [7:0]  p_x0 = '0, p_x1 = '0;
  logic [48:0]        p_mu0 = '0, p_mu1 = '0;
  logic signed [7:0]  p_incr;
  logic signed [23:0] p_ctrl;

  ts_fuzzy_incr #(.F0(7), .F1(7), .N(7), .V(8), .CW(8), .AW(24),
                  .VMIN(-400), .VMAX(400), .PIPE(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .x0_i(p_x0), .x1_i(p_x1),
    .mu0_i(p_mu0), .mu1_i(p_mu1), .incr_o(p_incr), .ctrl_o(p_ctrl)
  );

  function automatic int rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) & 32'h7fff);
  endfunction

  // Bench model of R1..R5
  function automatic int ref_incr(input int x0, input int x1, input int m0[7],
                                  input int m1[7], input int f0, input int f1,
                                  input int n, input int v);
    longint num = 0, den = 0, q, lim;
    for (int l = 0; l < f0; l++)
      for (int k = 0; k < f1; k++) begin
        int g = l * f1 + k;
        longint s = (m0[l] < m1[k]) ? m0[l] : m1[k];
        longint z = longint'((g*37)%97 - 48) * x0 + longint'((g*53)%89 - 44) * x1
                  + longint'((g*29)%61 - 30) * (longint'(1) << n);
        num += s * z;
        den += s;
      end
    if (den == 0) return 0;
    q = num / (den << n);
    lim = longint'(1) << (v - 1);
    if (q > lim - 1) q = lim - 1;
    if (q < -lim) q = -lim;
    return int'(q);
  endfunction

  function automatic longint clampv(input longint a, input longint lo, input longint hi);
    if (a > hi) return hi;
    if (a < lo) return lo;
    return a;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    ncheck++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive_os(input int x0, input int x1, input int m0[7], input int m1[7]);
    os_x0 = 5'(x0);
    os_x1 = 5'(x1);
    for (int j = 0; j < 3; j++) begin
      os_mu0[j*4 +: 4] = 4'(m0[j]);
      os_mu1[j*4 +: 4] = 4'(m1[j]);
    end
  endtask

  int vx0 [NV];
  int vx1 [NV];
  int vm0 [NV][7];
  int vm1 [NV][7];
  int vexp [NV];

  initial begin
    int m0[7];
    int m1[7];
    int cnt;
    longint accm;

    // R10: state during and after reset
    repeat (3) @(negedge clk);
    chk("R10 incr in reset", p_incr, 0);
    chk("R10 ctrl in reset", p_ctrl, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 incr after reset", p_incr, 0);
    chk("R10 ctrl after reset", p_ctrl, 0);

    // R3/R4/R5/R6: exhaustive input sweep on the one-shot instance
    cnt = 0;
    for (int a = -16; a < 16; a++) begin
      for (int b = -16; b < 16; b++) begin
        int e;
        for (int j = 0; j < 7; j++) begin
          m0[j] = (j < 3) ? (rnd() & 15) : 0;
          m1[j] = (j < 3 && (cnt % 7) != 0) ? (rnd() & 15) : 0;
        end
        cnt++;
        @(negedge clk);
        drive_os(a, b, m0, m1);
        #1;
        e = ref_incr(a, b, m0, m1, 3, 3, 4, 5);
        if ((m0[0]|m0[1]|m0[2]) == 0 || (m1[0]|m1[1]|m1[2]) == 0)
          chk("R4 zero strength same-cycle R6", os_incr, e);
        else if (e == 15 || e == -16)
          chk("R5 saturation same-cycle R6", os_incr, e);
        else
          chk("R3 weighted average same-cycle R6", os_incr, e);
      end
    end

    // R1/R2: single rule firing reproduces its own consequent
    for (int l = 0; l < 3; l++)
      for (int k = 0; k < 3; k++) begin
        for (int j = 0; j < 7; j++) begin m0[j] = 0; m1[j] = 0; end
        m0[l] = 9; m1[k] = 13;
        @(negedge clk);
        drive_os(3, -2, m0, m1);
        #1;
        chk("R2 single-rule consequent", os_incr, ref_incr(3, -2, m0, m1, 3, 3, 4, 5));
      end
    // R1: two rules whose strengths come from the smaller degree
    for (int j = 0; j < 7; j++) begin m0[j] = 0; m1[j] = 0; end
    m0[0] = 15; m0[1] = 3; m1[0] = 6;
    @(negedge clk);
    drive_os(2, 1, m0, m1);
    #1;
    chk("R1 min strengths", os_incr, ref_incr(2, 1, m0, m1, 3, 3, 4, 5));
    m0[1] = 12; m1[0] = 2; m1[2] = 11;
    @(negedge clk);
    drive_os(-5, 7, m0, m1);
    #1;
    chk("R1 min strengths mixed", os_incr, ref_incr(-5, 7, m0, m1, 3, 3, 4, 5));

    // Build pipeline stimulus: first a rising phase, then a falling phase
    for (int c = 0; c < NV; c++) begin
      int e;
      int tries = 0;
      do begin
        vx0[c] = (rnd() % 256) - 128;
        vx1[c] = (rnd() % 256) - 128;
        for (int j = 0; j < 7; j++) begin
          m0[j] = rnd() & 127;
          m1[j] = rnd() & 127;
        end
        e = ref_incr(vx0[c], vx1[c], m0, m1, 7, 7, 7, 8);
        tries++;
      end while (tries < 3000 && ((c < 30) ? (e <= 20) : (e >= -20)));
      for (int j = 0; j < 7; j++) begin vm0[c][j] = m0[j]; vm1[c][j] = m1[j]; end
      vexp[c] = e;
    end

    // R7/R8/R9: latency, integration and clamping on the pipelined instance
    accm = 0;
    for (int c = 0; c < NV + 5; c++) begin
      longint ei;
      @(negedge clk);
      ei = (c >= 4 && c - 4 < NV) ? longint'(vexp[c-4]) : 0;
      chk("R7 four-cycle latency", p_incr, ei);
      chk("R8 R9 clamped running sum", p_ctrl, clampv(accm, -400, 400));
      if (c < NV) begin
        p_x0 = 8'(vx0[c]);
        p_x1 = 8'(vx1[c]);
        for (int j = 0; j < 7; j++) begin
          p_mu0[j*7 +: 7] = 7'(vm0[c][j]);
          p_mu1[j*7 +: 7] = 7'(vm1[c][j]);
        end
      end else begin
        p_mu0 = '0;
        p_mu1 = '0;
      end
      accm += ei;
    end

    $display("Simulation finished: %0d checks, %0d errors", ncheck, nerr);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    ncheck++;
    nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", ncheck, nerr);
    $finish;
  end

endmodule